// File: doc/BRIEF.md
# Cascaded Dual-CPU Interrupt Controller

This block gathers ninety-six level-sensitive interrupt sources into two main cause words (low and high) and a third cause word fed by thirty-two general-purpose pins. The pin word is not searched on its own. It is folded into four summary bits of the main high word, one bit for each group of eight pins. The first CPU gets the full set of enables and a priority-encoded readout of its pending interrupt number. The second CPU can be signalled only by the doorbell source, which is bit 28 of the main low word.

Software reaches every cause and mask word through a plain register port. Writes take effect at the clock edge and reads are combinational. Main cause bits are registered copies of their input levels. Pin cause bits are sticky: a pin that is high sets its bit, and software clears the bit by writing 0 to it. Each CPU interrupt output and the pending readout come combinationally from registered state, so they follow a source change, a mask write or a clear one clock edge later. The block carries no streaming data, so every pin is a plain control or status signal with no back-pressure.

Top module: `casc_intc`

## Requirements
- R1: After reset, all mask words and the pin cause word are 0, both CPU outputs are low and the readout shows the no-source code.
- R2: Main cause words are read at address 0 (low) and address 1 (high). They equal the source inputs captured at the last edge, except high bits 24..27, which come from the pin summary and never from `src_hi_i`.
- R3: Only low bits in 0x3DFFFFFE and high bits in 0x1F0003F7 are sources. Other bits never raise `cpu0_irq_o` or appear in the readout.
- R4: Priority runs in this order: a pending low-word source beats any high-word source, and within a word the highest enabled bit wins. Low bit n reports n, and high bit n reports 32+n.
- R5: High summary bit 24+k is the OR of (pin cause AND pin mask) over pins 8k..8k+7. When a summary bit is selected, the number reported is 64 plus the highest masked pending pin, across all 32 pins.
- R6: The pin cause word is at address 2. A pin that is high at an edge sets its bit. A write clears exactly the bits written as 0 and keeps those written as 1. A pin that is high overrides a clear in the same cycle.
- R7: The CPU1 mask word (address 5) stores only bit 28; all other bits read 0. `cpu1_irq_o` is high exactly when low cause bit 28 and that stored bit are both set.
- R8: `cpu0_irq_o` is high whenever any valid, CPU0-enabled cause bit is set. It drops one edge after the source goes low.
- R9: With no enabled source pending, `irq_num_valid_o` is 0 and `irq_num_o` reads 127.
- R10: The CPU0 low mask (address 3), CPU0 high mask (address 4) and pin mask (address 6) read back the full 32-bit value last written.
- R11: Address 7 reads the readout, with bit 31 set to the valid flag and bits 6..0 set to the number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_lo_i | input | 32 | Level sources for interrupt numbers 0..31 |
| src_hi_i | input | 32 | Level sources for numbers 32..63 (bits 24..27 unused) |
| gpp_pin_i | input | 32 | General-purpose pin levels, numbers 64..95 |
| reg_wen_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| cpu0_irq_o | output | 1 | Interrupt request to CPU0 |
| cpu1_irq_o | output | 1 | Doorbell request to CPU1 |
| irq_num_o | output | 7 | Selected interrupt number, or 127 |
| irq_num_valid_o | output | 1 | Readout holds a real source |

## Verification
The bench builds the block with its default parameters: 32-bit words, the two valid-source patterns above, four summary bits at 24..27 and the doorbell at bit 28. With these values the bench can drive the full numbering range up to 95, including the last pin of the last group. It can also drive every invalid bit of both words together, and it can exercise the case where one summary group outranks another while the pin selected comes from a different group.

// File: rtl/icx_pkg.sv
package icx_pkg;
  typedef enum logic [2:0] {
    RA_CAUSE_LO  = 3'd0,
    RA_CAUSE_HI  = 3'd1,
    RA_GPP_CAUSE = 3'd2,
    RA_MASK0_LO  = 3'd3,
    RA_MASK0_HI  = 3'd4,
    RA_MASK1_LO  = 3'd5,
    RA_GPP_MASK  = 3'd6,
    RA_PENDING   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/icx_prio_enc.sv
module icx_prio_enc #(
  parameter int W = 32,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // highest set bit wins: later iterations overwrite earlier ones
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/icx_cause_bank.sv
module icx_cause_bank #(
  parameter int W        = 32,
  parameter int SUM_BASE = 24,
  parameter int SUM_N    = 4,
  localparam int GRP     = W / SUM_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_lo_i,
  input  logic [W-1:0] src_hi_i,
  input  logic [W-1:0] gpp_pin_i,
  input  logic [W-1:0] gpp_mask_i,
  input  logic         gpp_wr_i,
  input  logic [W-1:0] gpp_wdata_i,
  output logic [W-1:0] cause_lo_o,
  output logic [W-1:0] cause_hi_o,
  output logic [W-1:0] gpp_cause_o
);
  logic [W-1:0]     lo_q, hi_q, gpp_q, gpp_d;
  logic [SUM_N-1:0] summary;
  logic [W-1:0]     sum_vec;

  // sticky pin causes: write-0 clears, a high pin overrides the clear
  always_comb begin
    gpp_d = gpp_wr_i ? (gpp_q & gpp_wdata_i) : gpp_q;
    gpp_d = gpp_d | gpp_pin_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      gpp_q <= '0;
    end else begin
      lo_q  <= src_lo_i;
      hi_q  <= src_hi_i;
      gpp_q <= gpp_d;
    end
  end

  for (genvar k = 0; k < SUM_N; k++) begin : g_sum
    assign summary[k] = |(gpp_q[k*GRP +: GRP] & gpp_mask_i[k*GRP +: GRP]);
  end

  // splice the summary field into the high word
  always_comb begin
    sum_vec = hi_q;
    for (int k = 0; k < SUM_N; k++) sum_vec[SUM_BASE+k] = summary[k];
  end

  assign cause_lo_o  = lo_q;
  assign cause_hi_o  = sum_vec;
  assign gpp_cause_o = gpp_q;

  a_r6_gpp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gpp_wr_i) |-> ((gpp_q & $past(gpp_q)) == $past(gpp_q)));
endmodule

// File: rtl/icx_mask_bank.sv
module icx_mask_bank
  import icx_pkg::*;
#(
  parameter int W        = 32,
  parameter int DOORBELL = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  reg_addr_e    addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] m0_lo_o,
  output logic [W-1:0] m0_hi_o,
  output logic [W-1:0] m1_lo_o,
  output logic [W-1:0] gpp_mask_o
);
  logic [W-1:0] m0_lo_q, m0_hi_q, gmask_q;
  logic         m1_db_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m0_lo_q <= '0;
      m0_hi_q <= '0;
      gmask_q <= '0;
      m1_db_q <= 1'b0;
    end else if (wr_i) begin
      case (addr_i)
        RA_MASK0_LO: m0_lo_q <= wdata_i;
        RA_MASK0_HI: m0_hi_q <= wdata_i;
        RA_MASK1_LO: m1_db_q <= wdata_i[DOORBELL];
        RA_GPP_MASK: gmask_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign m0_lo_o    = m0_lo_q;
  assign m0_hi_o    = m0_hi_q;
  assign gpp_mask_o = gmask_q;
  assign m1_lo_o    = W'(m1_db_q) << DOORBELL;

  a_r10_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_i) |-> ($stable(m0_lo_q) && $stable(m0_hi_q) && $stable(gmask_q)));
endmodule

// File: rtl/icx_pending_sel.sv
module icx_pending_sel #(
  parameter int W        = 32,
  parameter int SUM_BASE = 24,
  parameter int SUM_N    = 4,
  localparam int NUM_W   = $clog2(3*W),
  localparam int IW      = $clog2(W)
) (
  input  logic [W-1:0]     en_lo_i,
  input  logic [W-1:0]     en_hi_i,
  input  logic [W-1:0]     en_gpp_i,
  output logic [NUM_W-1:0] num_o,
  output logic             valid_o
);
  logic [IW-1:0] lo_idx, hi_idx, gpp_idx;
  logic          lo_any, hi_any, gpp_any, hi_is_sum;

  icx_prio_enc #(.W(W)) u_lo  (.vec_i(en_lo_i),  .idx_o(lo_idx),  .any_o(lo_any));
  icx_prio_enc #(.W(W)) u_hi  (.vec_i(en_hi_i),  .idx_o(hi_idx),  .any_o(hi_any));
  icx_prio_enc #(.W(W)) u_gpp (.vec_i(en_gpp_i), .idx_o(gpp_idx), .any_o(gpp_any));

  assign hi_is_sum = (int'(hi_idx) >= SUM_BASE) && (int'(hi_idx) < SUM_BASE + SUM_N);

  always_comb begin
    num_o   = '1;
    valid_o = 1'b0;
    if (lo_any) begin
      num_o   = NUM_W'(lo_idx);
      valid_o = 1'b1;
    end else if (hi_any) begin
      if (!hi_is_sum) begin
        num_o   = NUM_W'(W) + NUM_W'(hi_idx);
        valid_o = 1'b1;
      end else if (gpp_any) begin
        num_o   = NUM_W'(2*W) + NUM_W'(gpp_idx);
        valid_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/casc_intc.sv
module casc_intc
  import icx_pkg::*;
#(
  parameter int          WORD_W   = 32,
  parameter logic [31:0] VALID_LO = 32'h3DFF_FFFE,
  parameter logic [31:0] VALID_HI = 32'h1F00_03F7,
  parameter int          SUM_BASE = 24,
  parameter int          SUM_N    = 4,
  parameter int          DOORBELL = 28,
  localparam int         NUM_W    = $clog2(3*WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] src_lo_i,
  input  logic [WORD_W-1:0] src_hi_i,
  input  logic [WORD_W-1:0] gpp_pin_i,
  input  logic              reg_wen_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              cpu0_irq_o,
  output logic              cpu1_irq_o,
  output logic [NUM_W-1:0]  irq_num_o,
  output logic              irq_num_valid_o
);
  localparam logic [WORD_W-1:0] VL = WORD_W'(VALID_LO);
  localparam logic [WORD_W-1:0] VH = WORD_W'(VALID_HI);

  reg_addr_e         addr;
  logic [WORD_W-1:0] cause_lo, cause_hi, gpp_cause;
  logic [WORD_W-1:0] m0_lo, m0_hi, m1_lo, gpp_mask;
  logic [WORD_W-1:0] en_lo, en_hi;
  logic              gpp_wr;

  assign addr   = reg_addr_e'(reg_addr_i);
  assign gpp_wr = reg_wen_i && (addr == RA_GPP_CAUSE);

  icx_cause_bank #(.W(WORD_W), .SUM_BASE(SUM_BASE), .SUM_N(SUM_N)) u_cause (
    .clk(clk), .rst_n(rst_n),
    .src_lo_i(src_lo_i), .src_hi_i(src_hi_i), .gpp_pin_i(gpp_pin_i),
    .gpp_mask_i(gpp_mask), .gpp_wr_i(gpp_wr), .gpp_wdata_i(reg_wdata_i),
    .cause_lo_o(cause_lo), .cause_hi_o(cause_hi), .gpp_cause_o(gpp_cause)
  );

  icx_mask_bank #(.W(WORD_W), .DOORBELL(DOORBELL)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wen_i), .addr_i(addr),
    .wdata_i(reg_wdata_i), .m0_lo_o(m0_lo), .m0_hi_o(m0_hi),
    .m1_lo_o(m1_lo), .gpp_mask_o(gpp_mask)
  );

  assign en_lo = cause_lo & VL & m0_lo;
  assign en_hi = cause_hi & VH & m0_hi;

  icx_pending_sel #(.W(WORD_W), .SUM_BASE(SUM_BASE), .SUM_N(SUM_N)) u_sel (
    .en_lo_i(en_lo), .en_hi_i(en_hi), .en_gpp_i(gpp_cause & gpp_mask),
    .num_o(irq_num_o), .valid_o(irq_num_valid_o)
  );

  assign cpu0_irq_o = (|en_lo) || (|en_hi);
  assign cpu1_irq_o = cause_lo[DOORBELL] & m1_lo[DOORBELL];

  always_comb begin
    case (addr)
      RA_CAUSE_LO:  reg_rdata_o = cause_lo;
      RA_CAUSE_HI:  reg_rdata_o = cause_hi;
      RA_GPP_CAUSE: reg_rdata_o = gpp_cause;
      RA_MASK0_LO:  reg_rdata_o = m0_lo;
      RA_MASK0_HI:  reg_rdata_o = m0_hi;
      RA_MASK1_LO:  reg_rdata_o = m1_lo;
      RA_GPP_MASK:  reg_rdata_o = gpp_mask;
      default: begin
        reg_rdata_o = WORD_W'(irq_num_o);
        reg_rdata_o[WORD_W-1] = irq_num_valid_o;
      end
    endcase
  end

  a_r7_cpu1_doorbell_only: assert property (@(posedge clk) disable iff (!rst_n)
    cpu1_irq_o |-> cause_lo[DOORBELL]);
  a_r9_spurious_code: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_num_valid_o |-> (irq_num_o == '1));
  a_r3_num_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq_num_valid_o |-> (int'(irq_num_o) < 3*WORD_W));
  a_r8_valid_has_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_num_valid_o |-> cpu0_irq_o);
  a_r4_low_first: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_lo) |-> (irq_num_valid_o && int'(irq_num_o) < WORD_W));
endmodule

// File: tb/casc_intc_tb_top.sv
module casc_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lo = '0, src_hi = '0, gpp_pin = '0, wdata = '0;
  logic        wen = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] rdata;
  logic        cpu0, cpu1, nvalid;
  logic [6:0]  num;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  casc_intc dut_i (
    .clk(clk), .rst_n(rst_n), .src_lo_i(src_lo), .src_hi_i(src_hi),
    .gpp_pin_i(gpp_pin), .reg_wen_i(wen), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cpu0_irq_o(cpu0),
    .cpu1_irq_o(cpu1), .irq_num_o(num), .irq_num_valid_o(nvalid)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    addr = a; wdata = d; wen = 1'b1;
    step();
    wen = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 2; a < 7; a++) begin
      rd(3'(a), v);
      check("R1 reg zero", v, 0);
    end
    check("R1 cpu0", 32'(cpu0), 0);
    check("R1 cpu1", 32'(cpu1), 0);
    check("R9 idle num", 32'(num), 127);
    check("R9 idle valid", 32'(nvalid), 0);
  endtask

  task automatic t_mask_rw();
    logic [31:0] v;
    wr(3, 32'hA5A5_5A5A); rd(3, v); check("R10 mask0 lo", v, 32'hA5A5_5A5A);
    wr(4, 32'h1234_5678); rd(4, v); check("R10 mask0 hi", v, 32'h1234_5678);
    wr(6, 32'hDEAD_BEEF); rd(6, v); check("R10 gpp mask", v, 32'hDEAD_BEEF);
    wr(5, 32'hFFFF_FFFF); rd(5, v); check("R7 mask1 only db", v, 32'h1000_0000);
    wr(5, 32'hEFFF_FFFF); rd(5, v); check("R7 mask1 cleared", v, 0);
    wr(3, 0); wr(4, 0); wr(6, 0);
  endtask

  task automatic t_cause_follow();
    logic [31:0] v;
    src_lo = 32'h1234_5678; src_hi = 32'hFFFF_FFFF;
    step();
    rd(0, v); check("R2 cause lo", v, 32'h1234_5678);
    rd(1, v); check("R2 cause hi summary from gpp", v, 32'hF0FF_FFFF);
    src_lo = 0; src_hi = 0;
    step();
    rd(0, v); check("R2 cause lo follows", v, 0);
  endtask

  task automatic t_invalid();
    wr(3, 32'hFFFF_FFFF); wr(4, 32'hFFFF_FFFF);
    src_lo = 32'hC200_0001; src_hi = 32'hE0FF_FC08;
    step();
    check("R3 cpu0 quiet", 32'(cpu0), 0);
    check("R3 no valid", 32'(nvalid), 0);
    check("R9 code", 32'(num), 127);
    src_lo = 0; src_hi = 0;
    step();
  endtask

  task automatic t_priority();
    logic [31:0] v;
    src_lo = (1 << 3) | (1 << 9); src_hi = 1 << 5;
    step();
    check("R4 low highest", 32'(num), 9);
    src_lo = 0;
    step();
    check("R4 high word", 32'(num), 37);
    src_lo = (1 << 3) | (1 << 9);
    wr(3, ~(32'h1 << 9));
    check("R4 masked bit skipped", 32'(num), 3);
    rd(7, v); check("R11 pending reg", v, 32'h8000_0003);
    wr(3, 32'hFFFF_FFFF);
    src_lo = 1 << 1; src_hi = 1;
    step();
    check("R4 low beats high", 32'(num), 1);
    src_lo = 0; src_hi = 0;
    step();
    rd(7, v); check("R11 pending idle", v, 32'h0000_007F);
  endtask

  task automatic t_level();
    src_lo = 1 << 2;
    step();
    check("R8 cpu0 up", 32'(cpu0), 1);
    src_lo = 0;
    step();
    check("R8 cpu0 drops", 32'(cpu0), 0);
  endtask

  task automatic pulse(int p);
    gpp_pin = 32'h1 << p;
    step();
    gpp_pin = 0;
  endtask

  task automatic t_gpp();
    logic [31:0] v;
    wr(3, 0); wr(4, 32'h0F00_0000); wr(6, 32'hFFFF_FFFF);
    pulse(18);
    rd(2, v); check("R6 pin sets", v, 32'h0004_0000);
    rd(1, v); check("R5 summary bit 26", v, 32'h0400_0000);
    check("R5 num 82", 32'(num), 82);
    check("R8 cpu0 from pin", 32'(cpu0), 1);
    pulse(5);
    check("R5 highest pin", 32'(num), 82);
    wr(2, ~(32'h1 << 18));
    rd(2, v); check("R6 one bit cleared", v, 32'h20);
    check("R5 num 69", 32'(num), 69);
    wr(2, 32'hFFFF_FFFF);
    rd(2, v); check("R6 write one keeps", v, 32'h20);
    wr(6, ~(32'h1 << 5));
    rd(1, v); check("R5 pin mask hides", v, 0);
    check("R5 cpu0 masked", 32'(cpu0), 0);
    wr(6, 32'hFFFF_FFFF);
    gpp_pin = 32'h20;
    wr(2, 0);
    rd(2, v); check("R6 pin overrides clear", v, 32'h20);
    gpp_pin = 0;
    wr(2, 0);
    rd(2, v); check("R6 cleared", v, 0);
    check("R9 after clear", 32'(nvalid), 0);
    pulse(31);
    check("R5 num 95", 32'(num), 95);
    rd(1, v); check("R5 summary bit 27", v, 32'h0800_0000);
    wr(2, 0);
  endtask

  task automatic t_cpu1();
    wr(3, 0); wr(4, 0); wr(5, 32'hFFFF_FFFF);
    src_lo = 32'h1 << 28;
    step();
    check("R7 cpu1 doorbell", 32'(cpu1), 1);
    check("R7 cpu0 masked", 32'(cpu0), 0);
    src_lo = ~(32'h1 << 28);
    step();
    check("R7 cpu1 other bits", 32'(cpu1), 0);
    src_lo = 32'h1 << 28;
    wr(5, 0);
    check("R7 cpu1 masked", 32'(cpu1), 0);
    src_lo = 0;
    step();
  endtask

  initial begin : wd
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask_rw();
    t_cause_follow();
    t_invalid();
    t_priority();
    t_level();
    t_gpp();
    t_cpu1();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule